// File: doc/BRIEF.md
# Ping-Pong Sprite Line Buffer

This block assembles the sprite pixels of one scanline while the scanline before it is being shown. It has two line memories of 256 entries, each entry eight bits wide, and the two memories trade roles at every line-start strobe. One memory takes renderer writes. The other is read in display order and cleared. A pixel handed to the renderer side therefore reaches the display exactly one line later.

A render write gives the left edge of a sprite, a 5-bit offset inside the 32-pixel sprite row, a horizontal flip flag, a 4-bit colour index and a 4-bit palette bank. The target location is the left edge plus the offset. When the flip flag is set, it is the left edge plus 31 minus the offset. Locations wrap modulo 256.

Colour index 0 marks a transparent pixel, and the block never stores it. The first opaque pixel written to a location during a line is kept, and later writes to that location are dropped, so sprites written earlier appear in front. On the scan-out side, each read returns the stored entry one cycle later and writes zero back to the location in the same cycle. A buffer is therefore empty again before it becomes the write buffer.

Top module: `sprite_linebuf`

## Requirements
- R1: After reset `pix_valid` is 0 and every location of both buffers reads back as colour 0, bank 0.
- R2: Each `line_start` swaps the buffers. Pixels written between two strobes are readable only after the second strobe of the pair, which gives a delay of exactly one line.
- R3: A read request (`rd_en` high with address `rd_x`) in cycle N gives `pix_valid` high with that location's entry in cycle N+1. With no request in cycle N, `pix_valid` is low in cycle N+1.
- R4: A write with `wr_color` equal to 0 is transparent and leaves the target location unchanged.
- R5: Within one line, the first opaque write to a location is kept, and any later write to the same location is ignored.
- R6: A read clears the location it reads. A second read of that location, or a read of it after the buffer comes round again, returns 0.
- R7: The target location is `wr_base_x + wr_offs` when `wr_flip` is 0, and `wr_base_x + 31 - wr_offs` when `wr_flip` is 1.
- R8: Writes go only to the write buffer, so writes made during a line never show up in that line's scan-out.
- R9: The stored entry is returned unchanged, with `pix_color` equal to the written colour index and `pix_bank` equal to the written palette bank.
- R10: Target locations wrap modulo 256. A sprite whose left edge is near 255 continues at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe that swaps the buffers |
| wr_en | input | 1 | Render pixel write request |
| wr_base_x | input | 8 | Left edge of the sprite on the line |
| wr_offs | input | 5 | Pixel offset within the 32-pixel sprite row |
| wr_flip | input | 1 | Horizontal flip of the sprite row |
| wr_color | input | 4 | Colour index, where 0 means transparent |
| wr_bank | input | 4 | Palette bank of the pixel |
| rd_en | input | 1 | Scan-out read request |
| rd_x | input | 8 | Scan-out location |
| pix_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| pix_color | output | 4 | Colour index read from the scan-out buffer |
| pix_bank | output | 4 | Palette bank read from the scan-out buffer |

## Verification
The first pattern is an unflipped sprite row with transparent holes. It shows whether zero-colour pixels are skipped and whether offsets map to the right locations. The second pattern overlaps that row with a flipped row of a different colour and bank. This separates first-wins from last-wins and checks the direction of the flipped offsets. The third pattern places a sprite row across location 255 during a line while the other buffer is being read. This tests wrap-around and confirms that writes cannot leak into the current scan-out. The last pattern repeats reads and reads a buffer again after it comes round, which shows that reads clear locations.

// File: rtl/slb_pkg.sv
package slb_pkg;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_id_e;

    function automatic buf_id_e other_buf(input buf_id_e b);
        return (b == BUF_A) ? BUF_B : BUF_A;
    endfunction

endpackage

// File: rtl/slb_xmap.sv
module slb_xmap #(
    parameter int X_W     = 8,
    parameter int SPAN_W  = 5,
    parameter int COLOR_W = 4,
    parameter bit FLIP_EN = 1'b1
) (
    input  logic               wr_en,
    input  logic [X_W-1:0]     base_x,
    input  logic [SPAN_W-1:0]  offs,
    input  logic               flip,
    input  logic [COLOR_W-1:0] color,
    output logic [X_W-1:0]     tgt_x,
    output logic               solid
);
    localparam int PAD_W = X_W - SPAN_W;

    logic [SPAN_W-1:0] eff_offs;

    generate
        if (FLIP_EN) begin : g_flip
            // all-ones minus offs == ~offs for an SPAN_W-bit field
            always_comb eff_offs = flip ? ~offs : offs;
        end else begin : g_noflip
            always_comb eff_offs = offs;
        end
    endgenerate

    always_comb begin
        tgt_x = base_x + {{PAD_W{1'b0}}, eff_offs};
        solid = wr_en && (color != '0);
    end
endmodule

// File: rtl/slb_bank.sv
module slb_bank #(
    parameter int X_W     = 8,
    parameter int ENTRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [X_W-1:0]     wr_x,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               rd_req,
    input  logic [X_W-1:0]     rd_x,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               commit
);
    localparam int DEPTH = 1 << X_W;

    logic [ENTRY_W-1:0] mem_q [DEPTH];
    logic [ENTRY_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d   = mem_q;
        rd_data = mem_q[rd_x];
        // only an empty location accepts a pixel: first opaque write wins
        commit  = wr_req && (mem_q[wr_x] == '0);
        if (commit) begin
            mem_d[wr_x] = wr_data;
        end
        if (rd_req) begin
            mem_d[rd_x] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end
endmodule

// File: rtl/slb_ctrl.sv
module slb_ctrl
    import slb_pkg::*;
#(
    parameter int ENTRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               rd_en,
    input  logic [ENTRY_W-1:0] rd_entry,
    output buf_id_e            wr_buf,
    output logic               pix_valid,
    output logic [ENTRY_W-1:0] pix_entry
);
    typedef struct packed {
        buf_id_e            wbuf;
        logic               valid;
        logic [ENTRY_W-1:0] pix;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_en;
        if (rd_en) begin
            st_d.pix = rd_entry;
        end
        if (line_start) begin
            st_d.wbuf = other_buf(st_q.wbuf);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{wbuf: BUF_A, valid: 1'b0, pix: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_buf    = st_q.wbuf;
    assign pix_valid = st_q.valid;
    assign pix_entry = st_q.pix;
endmodule

// File: rtl/sprite_linebuf.sv
module sprite_linebuf
    import slb_pkg::*;
#(
    parameter int X_W     = 8,
    parameter int SPAN_W  = 5,
    parameter int COLOR_W = 4,
    parameter int BANK_W  = 4,
    parameter bit FLIP_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               wr_en,
    input  logic [X_W-1:0]     wr_base_x,
    input  logic [SPAN_W-1:0]  wr_offs,
    input  logic               wr_flip,
    input  logic [COLOR_W-1:0] wr_color,
    input  logic [BANK_W-1:0]  wr_bank,
    input  logic               rd_en,
    input  logic [X_W-1:0]     rd_x,
    output logic               pix_valid,
    output logic [COLOR_W-1:0] pix_color,
    output logic [BANK_W-1:0]  pix_bank
);
    localparam int ENTRY_W = BANK_W + COLOR_W;
    localparam int NBUF    = 2;

    logic [X_W-1:0]     tgt_x;
    logic               solid;
    buf_id_e            buf_sel;
    logic [ENTRY_W-1:0] wr_entry;
    logic [ENTRY_W-1:0] bank_rd     [NBUF];
    logic [NBUF-1:0]    bank_commit;
    logic [ENTRY_W-1:0] rd_entry;
    logic [ENTRY_W-1:0] pix_entry;

    assign wr_entry = {wr_bank, wr_color};

    slb_xmap #(
        .X_W    (X_W),
        .SPAN_W (SPAN_W),
        .COLOR_W(COLOR_W),
        .FLIP_EN(FLIP_EN)
    ) u_xmap (
        .wr_en (wr_en),
        .base_x(wr_base_x),
        .offs  (wr_offs),
        .flip  (wr_flip),
        .color (wr_color),
        .tgt_x (tgt_x),
        .solid (solid)
    );

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_buf
            logic is_wr;
            assign is_wr = (buf_sel == buf_id_e'(g));

            slb_bank #(
                .X_W    (X_W),
                .ENTRY_W(ENTRY_W)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_req (solid && is_wr),
                .wr_x   (tgt_x),
                .wr_data(wr_entry),
                .rd_req (rd_en && !is_wr),
                .rd_x   (rd_x),
                .rd_data(bank_rd[g]),
                .commit (bank_commit[g])
            );
        end
    endgenerate

    assign rd_entry = (buf_sel == BUF_A) ? bank_rd[1] : bank_rd[0];

    slb_ctrl #(
        .ENTRY_W(ENTRY_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .rd_en     (rd_en),
        .rd_entry  (rd_entry),
        .wr_buf    (buf_sel),
        .pix_valid (pix_valid),
        .pix_entry (pix_entry)
    );

    assign pix_color = pix_entry[COLOR_W-1:0];
    assign pix_bank  = pix_entry[ENTRY_W-1:COLOR_W];
endmodule

// File: rtl/sprite_linebuf_chk.sv
module sprite_linebuf_chk #(
    parameter int COLOR_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               line_start,
    input logic               rd_en,
    input logic               wr_en,
    input logic [COLOR_W-1:0] wr_color,
    input logic               buf_sel,
    input logic               commit,
    input logic               pix_valid
);
    // R1: no read data right after reset
    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !pix_valid);

    // R3: read request gives valid data next cycle
    p_valid_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> pix_valid);

    // R3: no request, no valid data
    p_quiet_without_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !pix_valid);

    // R2: a strobe swaps the buffers
    p_swap_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (buf_sel != $past(buf_sel)));

    // R2: buffers hold their roles between strobes
    p_hold_between_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(buf_sel));

    // R4: a stored pixel always comes from an opaque write
    p_no_transparent_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (wr_en && (wr_color != '0)));
endmodule

bind sprite_linebuf sprite_linebuf_chk #(
    .COLOR_W(COLOR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_color  (wr_color),
    .buf_sel   (buf_sel),
    .commit    (|bank_commit),
    .pix_valid (pix_valid)
);

// File: tb/sprite_linebuf_bench.sv
module sprite_linebuf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_base_x = '0;
    logic [4:0] wr_offs = '0;
    logic       wr_flip = 1'b0;
    logic [3:0] wr_color = '0;
    logic [3:0] wr_bank = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_x = '0;
    logic       pix_valid;
    logic [3:0] pix_color;
    logic [3:0] pix_bank;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    logic [7:0] mdl [2][256];
    int    wsel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprite_linebuf u_sprite_linebuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .wr_en     (wr_en),
        .wr_base_x (wr_base_x),
        .wr_offs   (wr_offs),
        .wr_flip   (wr_flip),
        .wr_color  (wr_color),
        .wr_bank   (wr_bank),
        .rd_en     (rd_en),
        .rd_x      (rd_x),
        .pix_valid (pix_valid),
        .pix_color (pix_color),
        .pix_bank  (pix_bank)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // R7 / R10: expected target, modulo 256
    function automatic logic [7:0] target(input logic [7:0] b, input int o, input bit f);
        return 8'(int'(b) + (f ? (31 - o) : o));
    endfunction

    task automatic put_px(input logic [7:0] b, input int o, input bit f,
                          input logic [3:0] c, input logic [3:0] k);
        logic [7:0] x;
        @(negedge clk);
        rd_en = 1'b0; line_start = 1'b0;
        wr_en = 1'b1; wr_base_x = b; wr_offs = 5'(o); wr_flip = f;
        wr_color = c; wr_bank = k;
        x = target(b, o, f);
        if (c != 4'd0 && mdl[wsel][x] == 8'd0) mdl[wsel][x] = {k, c};
    endtask

    task automatic get_px(input logic [7:0] x, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0; line_start = 1'b0;
        rd_en = 1'b1; rd_x = x;
        it.exp = mdl[1 - wsel][x];
        it.tag = tag;
        mdl[1 - wsel][x] = 8'd0;
        sb_q.push_back(it);
    endtask

    task automatic next_line();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        wsel = 1 - wsel;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; line_start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare scan-out against the scoreboard
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3 unexpected pix_valid", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check({pix_bank, pix_color} == it.exp, it.tag,
                      int'({pix_bank, pix_color}), int'(it.exp));
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 256; i++) mdl[b][i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_valid == 1'b0, "R1 pix_valid after reset", int'(pix_valid), 0);

        // R1: empty buffer after reset
        for (int i = 0; i < 256; i += 37) get_px(8'(i), "R1 empty after reset");
        idle(2);

        // line 0: sprite A unflipped with holes (R4, R7), sprite B flipped overlap (R5, R7)
        for (int o = 0; o < 32; o++) put_px(8'd10, o, 1'b0, 4'(o % 16), 4'h1);
        for (int o = 0; o < 32; o++) put_px(8'd20, o, 1'b1, 4'hA, 4'h2);
        // R8: nothing written this line may appear in the current read buffer
        for (int i = 8; i < 56; i += 5) get_px(8'(i), "R8 no leak into scan-out");
        next_line();

        // line 1: scan out line 0 (R2, R4, R5, R7, R9), meanwhile sprite C wraps (R10)
        for (int i = 0; i < 64; i++) get_px(8'(i), "R2 R5 R7 R9 delayed line");
        get_px(8'd15, "R6 second read returns zero");
        get_px(8'd30, "R6 second read returns zero");
        for (int o = 0; o < 32; o++) put_px(8'd240, o, 1'b0, 4'(1 + o % 15), 4'h3);
        for (int i = 240; i < 256; i++) get_px(8'(i), "R8 no leak into scan-out");
        next_line();

        // line 2: scan out sprite C across the wrap
        for (int i = 236; i < 256; i++) get_px(8'(i), "R10 wrap upper part");
        for (int i = 0; i < 20; i++) get_px(8'(i), "R10 wrap lower part");
        next_line();

        // line 3: buffer used for line 0 comes round again, must be empty
        for (int i = 0; i < 64; i++) get_px(8'(i), "R6 cleared after read");
        // R4: transparent write over an empty location into write buffer
        put_px(8'd100, 0, 1'b0, 4'h0, 4'hF);
        put_px(8'd100, 1, 1'b1, 4'h5, 4'h7);
        next_line();
        get_px(8'd100, "R4 transparent write ignored");
        get_px(8'd130, "R7 flipped offset one");
        idle(3);

        check(sb_q.size() == 0, "R3 every read returned", sb_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule